// File: doc/BRIEF.md
# Three-Channel PWM Generator with Two Selectable Timebases

This block produces three pulse-width-modulated outputs from two 8-bit timers. Each timer counts from zero up to its own period value and then wraps to zero. A timer advances once per instruction cycle, and every instruction cycle lasts four core clocks. It counts either on the internal instruction clock or on rising edges of an external clock pin. The external pin is synchronized before the timer uses it.

Each channel compares a 10-bit duty value with the count of the timer it follows. In internal mode, the two-bit instruction-cycle phase forms the two low bits of that count. This gives quarter-instruction-cycle resolution. In external mode, the phase bits are forced to zero, so only 8-bit resolution is available. Channel 1 always follows timer 1. Channels 2 and 3 can each follow either timer.

Software programs the block through a simple write port. New duty values are double-buffered and take effect at the next wrap of the channel's timer. Each timer raises a sticky flag when it wraps. Software clears the flag by pulsing a write-one-to-clear strobe.

Top module: `pwm3_timebase`

## Requirements
- R1: After reset, all three outputs are low, both wrap flags are clear, both timers are off and their counters are zero.
- R2: A timer that is on in internal mode advances only at the core-clock edge that ends phase 3 of `cyc_ph`. It wraps to zero after it reaches its period value P. The output period is therefore 4*(P+1) core clocks.
- R3: The duty value is 10 bits. Bits 9..2 are written at address 4, 6 or 8 (channel 1, 2 or 3). Bits 1..0 are taken from write-data bits 7:6 at address 5, 7 or 9. In internal mode an output stays high for exactly duty core clocks, counted from the wrap.
- R4: A duty of zero holds the output low. A duty of at least 4*(P+1) holds the output high. A duty of 4*P+3 gives a high time one clock shorter than the period.
- R5: Duty writes go to a shadow copy. The pulse in progress keeps the old duty. The new duty applies from the next wrap of the channel's timer.
- R6: Address 1 controls channel routing. Bits 2:0 enable channels 3..1. Bit 3 set routes channel 2 to timer 2. Bit 4 set routes channel 3 to timer 2. When a bit is clear, that channel uses timer 1. Channel 1 always uses timer 1.
- R7: A channel whose enable bit is clear drives its output low.
- R8: Address 0 sets the timer modes. Bit 0 turns timer 1 on and bit 1 selects external mode for timer 1. Bits 2 and 3 do the same for timer 2. A timer that is off keeps its count, never wraps, and its outputs do not change. Addresses 2 and 3 hold the period values of timers 1 and 2.
- R9: `prd_flag[t]` is set when timer t+1 wraps. It stays set until `flag_clr[t]` is pulsed. If a wrap and a clear fall on the same edge, the wrap wins.
- R10: In external mode, the pin passes through a two-flop synchronizer and a rising-edge detector. Each detected edge advances the timer once, at the end of an instruction cycle. The phase bits are left out of the comparison, so a duty of 4*D gives a high time of D timer steps.
- R11: In external mode, a timer advances at most once per instruction cycle, however fast the pin toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_ph | input | 2 | Instruction-cycle phase, counts 0..3 |
| ext_clk | input | 1 | External timebase pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| flag_clr | input | 2 | Write-one-to-clear strobes for the wrap flags |
| pwm_out | output | 3 | PWM outputs, channel 1 in bit 0 |
| prd_flag | output | 2 | Sticky wrap flags, timer 1 in bit 0 |

## Verification
Each result has a fixed latency after its stimulus:
- A register write takes effect at the clock edge that samples it.
- The outputs are combinational on registered state. They change in the cycle that follows a timer step.
- A wrap flag rises at the same edge as the wrap.
- An external edge reaches the timer after two synchronizer stages, one edge-detect stage, and then a wait for the end of the instruction cycle.

Because of these latencies, the bench does not check on an absolute cycle number. A monitor samples each output at falling edges and records the high-run length and the rise-to-rise length. Checks are made only after a set number of further rising edges. This way, the effects of a duty load or a mode change have certainly taken hold.

Flag and freeze checks are made with the timers off, one falling edge after the clear pulse. This keeps a concurrent wrap from hiding the clear.

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int TW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_ph,
  input  logic          ext_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [1:0]    flag_clr,
  output logic [2:0]    pwm_out,
  output logic [1:0]    prd_flag
);
  localparam int DW = TW + 2;

  logic [1:0]    t_on, t_ext;
  logic [2:0]    ch_en;
  logic [1:0]    ch_sel;
  logic [TW-1:0] per [2];
  logic [TW-1:0] cnt [2];
  logic [DW-1:0] buf_d [3];
  logic [DW-1:0] act_d [3];
  logic [DW-1:0] xcnt [2];
  logic [1:0]    tick, roll;
  logic [2:0]    tsel;
  logic [2:0]    xs;
  logic          pend;

  wire ph_end = (cyc_ph == 2'd3);
  wire x_rise = xs[1] & ~xs[2];

  assign tsel = {ch_sel[1], ch_sel[0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_on   <= '0;
      t_ext  <= '0;
      ch_en  <= '0;
      ch_sel <= '0;
      for (int t = 0; t < 2; t++) per[t] <= '0;
      for (int c = 0; c < 3; c++) buf_d[c] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): {t_ext[1], t_on[1], t_ext[0], t_on[0]} <= wr_data[3:0];
        AW'(1): begin
          ch_en  <= wr_data[2:0];
          ch_sel <= wr_data[4:3];
        end
        AW'(2): per[0] <= wr_data;
        AW'(3): per[1] <= wr_data;
        default: begin
          for (int c = 0; c < 3; c++) begin
            if (wr_addr == AW'(4 + 2 * c)) buf_d[c][DW-1:2] <= wr_data;
            if (wr_addr == AW'(5 + 2 * c)) buf_d[c][1:0]    <= wr_data[TW-1:TW-2];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs   <= '0;
      pend <= 1'b0;
    end else begin
      xs   <= {xs[1:0], ext_clk};
      pend <= x_rise | (pend & ~ph_end);
    end
  end

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      tick[t] = t_on[t] & ph_end & (~t_ext[t] | pend);
      roll[t] = tick[t] & (cnt[t] == per[t]);
      xcnt[t] = {cnt[t], (t_on[t] & ~t_ext[t]) ? cyc_ph : 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) cnt[t] <= '0;
      prd_flag <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (roll[t])      cnt[t] <= '0;
        else if (tick[t]) cnt[t] <= cnt[t] + 1'b1;
        if (roll[t])          prd_flag[t] <= 1'b1;
        else if (flag_clr[t]) prd_flag[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) act_d[c] <= '0;
    end else begin
      for (int c = 0; c < 3; c++)
        if (roll[tsel[c]]) act_d[c] <= buf_d[c];
    end
  end

  always_comb begin
    for (int c = 0; c < 3; c++)
      pwm_out[c] = ch_en[c] & (xcnt[tsel[c]] < act_d[c]);
  end
endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cyc_ph,
  input logic [1:0]    flag_clr,
  input logic [1:0]    prd_flag,
  input logic [TW-1:0] cnt0,
  input logic [TW+1:0] act0
);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_flag[0] && !flag_clr[0]) |=> prd_flag[0]);

  p_flag_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prd_flag[0]) |-> (cnt0 == '0));

  p_tick_at_phase_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt0) |-> ($past(cyc_ph) == 2'd3));

  p_duty_load_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act0) |-> (cnt0 == '0));
endmodule

bind pwm3_timebase pwm3_checker #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_ph   (cyc_ph),
  .flag_clr (flag_clr),
  .prd_flag (prd_flag),
  .cnt0     (cnt[0]),
  .act0     (act_d[0])
);

// File: tb/tb_pwm3_timebase.sv
module tb_pwm3_timebase;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_ph = 2'd0;
  logic       ext_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] flag_clr = '0;
  logic [2:0] pwm_out;
  logic [1:0] prd_flag;

  int n_chk = 0, n_fail = 0, cyc = 0, ext_mode = 0, xc = 0;
  int hcnt[3], pcnt[3], hi_len[3], per_len[3], nrise[3];
  logic prev[3];

  pwm3_timebase dut (
    .clk(clk), .rst_n(rst_n), .cyc_ph(cyc_ph), .ext_clk(ext_clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_clr(flag_clr), .pwm_out(pwm_out), .prd_flag(prd_flag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cyc_ph <= rst_n ? cyc_ph + 2'd1 : 2'd0;
  end

  always @(negedge clk) begin
    xc <= xc + 1;
    case (ext_mode)
      1: ext_clk <= (xc % 8) < 4;
      2: ext_clk <= ~ext_clk;
      default: ext_clk <= 1'b0;
    endcase
  end

  initial for (int c = 0; c < 3; c++) begin
    hcnt[c] = 0; pcnt[c] = 0; hi_len[c] = -1; per_len[c] = -1; nrise[c] = 0; prev[c] = 1'b0;
  end

  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (pwm_out[c] && !prev[c]) begin
        per_len[c] = pcnt[c]; pcnt[c] = 1; hcnt[c] = 1; nrise[c]++;
      end else begin
        pcnt[c]++;
        if (pwm_out[c]) hcnt[c]++;
      end
      if (!pwm_out[c] && prev[c]) hi_len[c] = hcnt[c];
      prev[c] = pwm_out[c];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rises(input int c, input int n);
    int s = nrise[c];
    int k = 0;
    while (nrise[c] < s + n && k < 3000) begin
      @(negedge clk); k++;
    end
    if (k >= 3000) chk("watchdog wait_rises", 0, 1);
  endtask

  task automatic high_count(input int c, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[c]) h++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 prd_flag after reset", int'(prd_flag), 0);
  endtask

  task automatic t_basic;
    wr(4'd2, 8'd9);
    wr(4'd4, 8'd5);
    wr(4'd5, 8'hC0);
    wr(4'd1, 8'b0000_0001);
    wr(4'd0, 8'b0000_0001);
    wait_rises(0, 3);
    chk("R2 ch1 period 4*(9+1)", per_len[0], 40);
    chk("R3 ch1 high time duty 23", hi_len[0], 23);
  endtask

  task automatic t_buffer;
    wait_rises(0, 1);
    wr(4'd4, 8'd2);
    wr(4'd5, 8'h00);
    wait_rises(0, 1);
    chk("R5 pulse in progress keeps old duty", hi_len[0], 23);
    wait_rises(0, 2);
    chk("R5 new duty after wrap", hi_len[0], 8);
  endtask

  task automatic t_extreme;
    int h;
    wr(4'd4, 8'd0);
    wr(4'd5, 8'h00);
    repeat (100) @(negedge clk);
    high_count(0, 40, h);
    chk("R4 duty zero constant low", h, 0);
    wr(4'd4, 8'd10);
    repeat (100) @(negedge clk);
    high_count(0, 40, h);
    chk("R4 duty 4*(P+1) constant high", h, 40);
    wr(4'd4, 8'd9);
    wr(4'd5, 8'hC0);
    wait_rises(0, 3);
    chk("R4 duty 4P+3 high time", hi_len[0], 39);
    chk("R4 duty 4P+3 period", per_len[0], 40);
  endtask

  task automatic t_select;
    wr(4'd3, 8'd4);
    wr(4'd0, 8'b0000_0101);
    wr(4'd6, 8'd2);
    wr(4'd7, 8'h40);
    wr(4'd1, 8'b0000_1011);
    wait_rises(1, 3);
    chk("R6 ch2 on timer2 period", per_len[1], 20);
    chk("R6 ch2 high time", hi_len[1], 9);
    wr(4'd8, 8'd3);
    wr(4'd9, 8'h00);
    wr(4'd1, 8'b0000_1111);
    wait_rises(2, 3);
    chk("R6 ch3 on timer1 period", per_len[2], 40);
    chk("R6 ch3 high time", hi_len[2], 12);
    wr(4'd1, 8'b0001_1111);
    wait_rises(2, 3);
    chk("R6 ch3 moved to timer2 period", per_len[2], 20);
  endtask

  task automatic t_disable;
    int h;
    wr(4'd1, 8'b0001_1101);
    high_count(1, 60, h);
    chk("R7 disabled ch2 stays low", h, 0);
  endtask

  task automatic t_flags_freeze;
    logic [2:0] held;
    int chg;
    wr(4'd0, 8'b0000_0000);
    chk("R9 flags sticky while set", int'(prd_flag), 3);
    held = pwm_out;
    @(negedge clk);
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
    chk("R9 flags cleared by strobe", int'(prd_flag), 0);
    chg = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out != held) chg++;
    end
    chk("R8 outputs held while timers off", chg, 0);
    chk("R8 no wrap while timers off", int'(prd_flag), 0);
    wr(4'd0, 8'b0000_0101);
    repeat (60) @(negedge clk);
    chk("R9 flag set again on wrap", int'(prd_flag), 3);
  endtask

  task automatic t_ext;
    wr(4'd2, 8'd3);
    wr(4'd4, 8'd2);
    wr(4'd5, 8'h00);
    ext_mode = 1;
    wr(4'd0, 8'b0000_0111);
    wait_rises(0, 4);
    chk("R10 ext period 4 steps of 8 clocks", per_len[0], 32);
    chk("R10 ext high 2 steps", hi_len[0], 16);
    ext_mode = 2;
    wait_rises(0, 4);
    chk("R11 fast ext limited to one step per cycle period", per_len[0], 16);
    chk("R11 fast ext high time", hi_len[0], 8);
    ext_mode = 0;
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_buffer();
        t_extreme();
        t_select();
        t_disable();
        t_flags_freeze();
        t_ext();
      end
      begin
        wait (cyc > 150000);
        chk("watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule